// File: doc/BRIEF.md
# Debug Scan-Chain Frame Decoder

This block sits behind a boundary-scan TAP controller and turns the serial data-register scans of the debug port into parallel accesses. It sees the TAP's capture, shift and update strobes and two decoded instruction flags. One flag picks chain selection and the other picks debug access. It samples `tdi` and drives `tdo`, and it runs entirely on the test clock. Every frame ends with a CRC-8 field. A frame takes effect only if that field matches the CRC the block computes over the bits that came before it.

With chain selection active, a frame names the target chain. With debug active, a frame carries one read or write access for that chain. A register-file chain uses a short address and goes to the register port. The bus chain and the four processor debug chains use a full 32-bit address and go to a shared system port, and `chain_id` tells the responder which target is meant. A read result is latched one cycle after the request. It is shifted out on `tdo` during the next frame, not the current one.

Top module: `jtag_dbg_frame_dec`

## Requirements
- R1: All fields enter on `tdi` least-significant bit first. A chain-selection frame has 4 identifier bits followed by 8 CRC bits. The identifier codes are 1 for the register chain, 2 for the bus chain, 3 for the trace chain and 8 to 11 for processor debug chains 0 to 3. Code 0 means no chain, and it is the value after reset.
- R2: The CRC is CRC-8 with polynomial x^8+x^2+x+1. It starts from all ones and is computed serially over the non-CRC bits in shift order. The received CRC bit i is compared with computed bit i. On the update strobe of a decoded frame, `crc_err` is set to 1 if the CRC fails and cleared to 0 if it passes. A failing frame causes no access and no chain change.
- R3: `chain_id` takes the received identifier in the cycle after the update strobe of a valid chain-selection frame, and it changes at no other time.
- R4: With the register chain selected, a debug frame has 5 address bits, 1 direction bit (1 = write, 0 = read), 32 data bits and 8 CRC bits. A valid frame raises `reg_req` for exactly one cycle, the cycle after the update strobe. In that cycle `acc_we`, `acc_addr` (zero-extended) and `acc_wdata` carry the frame's fields.
- R5: With the bus chain or a processor chain selected, a debug frame has 32 address bits, the direction bit, 32 data bits and 8 CRC bits. A valid frame raises `bus_req` for one cycle in the same way as R4.
- R6: With the trace chain or no chain selected, debug frames raise no request and leave `crc_err` and `chain_id` unchanged.
- R7: Read data is latched in the request cycle. On the next capture with debug active it is loaded for output. `tdo` then presents it LSB first from the first shift cycle, with zeros after 32 bits. Captures under chain selection present zeros.
- R8: `rdata_valid` is updated one cycle after a read request. For a register read it takes the value of `reg_ack`, so it is low for an address the register file does not have. For a bus read it is 1. A write request clears it.
- R9: A frame that stops before its last CRC bit is treated as a CRC failure. Bits shifted after the last CRC bit are ignored.
- R10: During reset, `chain_id`, `crc_err`, `reg_req`, `bus_req`, `rdata_valid` and `tdo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_dr | input | 1 | TAP capture strobe, starts a frame |
| shift_dr | input | 1 | TAP shift state, one bit per cycle |
| update_dr | input | 1 | TAP update strobe, ends a frame |
| ir_chain_sel | input | 1 | Chain-selection instruction active |
| ir_debug | input | 1 | Debug-access instruction active |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| chain_id | output | 4 | Selected chain code |
| crc_err | output | 1 | Last decoded frame failed its check |
| reg_req | output | 1 | One-cycle register-file access request |
| bus_req | output | 1 | One-cycle bus/processor access request |
| acc_we | output | 1 | Access direction, 1 = write |
| acc_addr | output | 32 | Access address |
| acc_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Register-file read data, valid in request cycle |
| reg_ack | input | 1 | Register address exists, valid in request cycle |
| bus_rdata | input | 32 | Bus read data, valid in request cycle |
| rdata_valid | output | 1 | Latched read data is valid |

## Verification
The assertions assume the TAP behaves like a TAP. `update_dr` is a one-cycle strobe with at least one other cycle between two of them. Capture, shift and update are never active together. The instruction flags are mutually exclusive and stay steady during a frame. The bench drives every frame as capture, a run of shift cycles, one exit cycle and then update, and it changes the instruction flags only between frames. Truncated frames and frames with extra bits still follow this strobe order, so only the length and CRC checks are exercised, not the assumptions themselves.

// File: rtl/jdbg_pkg.sv
// Shared constants, frame kinds and the serial CRC step for the debug frame decoder.
package jdbg_pkg;
    localparam int ID_W  = 4;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;

    localparam logic [ID_W-1:0] CH_NONE  = 4'h0;
    localparam logic [ID_W-1:0] CH_REG   = 4'h1;
    localparam logic [ID_W-1:0] CH_BUS   = 4'h2;
    localparam logic [ID_W-1:0] CH_TRACE = 4'h3;
    localparam logic [ID_W-1:0] CH_CPU0  = 4'h8;
    localparam logic [ID_W-1:0] CH_CPU3  = 4'hB;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_SELECT = 2'd1,
        FK_REG    = 2'd2,
        FK_BUS    = 2'd3
    } frame_kind_e;

    // One serial CRC step: MSB feedback XORed with the incoming bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/jdbg_crc8.sv
// Serial CRC accumulator. Preset to all ones on clear, one step per enabled cycle.
// Assumes clear and en are never active together.
module jdbg_crc8
    import jdbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    // Accumulate CRC over payload bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= CRC_INIT;
        else if (en)         crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/jdbg_frame_rx.sv
// Frame receiver: counts shifted bits, splits them into address, direction,
// data and CRC fields for the frame kind given, and reports frame_ok when the
// full length arrived and the CRC matches. Assumes kind is steady during a frame.
module jdbg_frame_rx
    import jdbg_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_AW = 5,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          shift,
    input  logic          tdi,
    input  frame_kind_e   kind,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic [DW-1:0] data,
    output logic          frame_ok
);
    localparam int MAX_LEN = AW + 1 + DW + CRC_W;
    localparam int CNT_W   = $clog2(MAX_LEN + 2);

    logic [CNT_W-1:0] cnt, alen, plen, flen;
    logic [AW-1:0]    addr_sr;
    logic [CRC_W-1:0] rx_crc, calc_crc;
    logic             in_addr, in_rw, in_data, in_crc, done;

    // Field lengths for the current frame kind.
    always_comb begin
        case (kind)
            FK_SELECT: begin alen = CNT_W'(ID_W);   plen = CNT_W'(ID_W);            end
            FK_REG:    begin alen = CNT_W'(REG_AW); plen = CNT_W'(REG_AW + 1 + DW); end
            default:   begin alen = CNT_W'(AW);     plen = CNT_W'(AW + 1 + DW);     end
        endcase
        flen = plen + CNT_W'(CRC_W);
    end

    // Position decode of the next bit.
    assign in_addr = cnt < alen;
    assign in_rw   = (kind != FK_SELECT) && (cnt == alen);
    assign in_data = (kind != FK_SELECT) && (cnt > alen) && (cnt < plen);
    assign in_crc  = (cnt >= plen) && (cnt < flen);
    assign done    = cnt >= flen;

    // Bit counter and field shift registers, bits beyond the frame ignored.
    always_ff @(posedge clk) begin
        if (!rst_n || capture) begin
            cnt     <= '0;
            addr_sr <= '0;
            rw      <= 1'b0;
            data    <= '0;
            rx_crc  <= '0;
        end else if (shift && !done) begin
            cnt <= cnt + 1'b1;
            if (in_addr) addr_sr <= {tdi, addr_sr[AW-1:1]};
            if (in_rw)   rw      <= tdi;
            if (in_data) data    <= {tdi, data[DW-1:1]};
            if (in_crc)  rx_crc  <= {tdi, rx_crc[CRC_W-1:1]};
        end
    end

    jdbg_crc8 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (capture),
        .en    (shift && (cnt < plen)),
        .din   (tdi),
        .crc   (calc_crc)
    );

    assign addr     = addr_sr >> (CNT_W'(AW) - alen);
    assign frame_ok = done && (rx_crc == calc_crc);

    // Once the frame is complete, further shift cycles leave the count alone.
    assert_extra_bits_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && done && !capture) |=> $stable(cnt));
endmodule

// File: rtl/jdbg_tx_shift.sv
// Output shifter: loads a word on capture and moves it out LSB first on tdo,
// filling with zeros. Assumes load and shift are never active together.
module jdbg_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         tdo
);
    logic [W-1:0] sr;

    // Load on capture, shift right on each shift cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= din;
        else if (shift) sr <= {1'b0, sr[W-1:1]};
    end

    assign tdo = sr[0];

    assert_tdo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(shift)) |-> $stable(tdo));
endmodule

// File: rtl/jtag_dbg_frame_dec.sv
// Debug scan-chain frame decoder top. Chooses the frame layout from the
// instruction flags and the selected chain, acts on valid frames at the update
// strobe, and keeps read data for the next frame.
// Assumes one-cycle update strobes, mutually exclusive instruction flags and
// combinational read responders valid in the request cycle.
module jtag_dbg_frame_dec
    import jdbg_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_AW = 5,
    parameter int DW     = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            ir_chain_sel,
    input  logic            ir_debug,
    input  logic            tdi,
    output logic            tdo,
    output logic [ID_W-1:0] chain_id,
    output logic            crc_err,
    output logic            reg_req,
    output logic            bus_req,
    output logic            acc_we,
    output logic [AW-1:0]   acc_addr,
    output logic [DW-1:0]   acc_wdata,
    input  logic [DW-1:0]   reg_rdata,
    input  logic            reg_ack,
    input  logic [DW-1:0]   bus_rdata,
    output logic            rdata_valid
);
    frame_kind_e   kind;
    logic [AW-1:0] rx_addr;
    logic [DW-1:0] rx_data, rbuf;
    logic          rx_rw, rx_ok, is_sys_chain;

    assign is_sys_chain = (chain_id == CH_BUS) || (chain_id >= CH_CPU0 && chain_id <= CH_CPU3);

    // Frame kind from the instruction and the current chain.
    always_comb begin
        if (ir_chain_sel)                          kind = FK_SELECT;
        else if (ir_debug && chain_id == CH_REG)   kind = FK_REG;
        else if (ir_debug && is_sys_chain)         kind = FK_BUS;
        else                                       kind = FK_NONE;
    end

    jdbg_frame_rx #(.AW(AW), .REG_AW(REG_AW), .DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .tdi      (tdi),
        .kind     (kind),
        .addr     (rx_addr),
        .rw       (rx_rw),
        .data     (rx_data),
        .frame_ok (rx_ok)
    );

    // Act on the update strobe: chain change, access request or error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_id  <= CH_NONE;
            crc_err   <= 1'b0;
            reg_req   <= 1'b0;
            bus_req   <= 1'b0;
            acc_we    <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else begin
            reg_req <= 1'b0;
            bus_req <= 1'b0;
            if (update_dr && kind != FK_NONE) begin
                crc_err <= !rx_ok;
                if (rx_ok) begin
                    if (kind == FK_SELECT) begin
                        chain_id <= rx_addr[ID_W-1:0];
                    end else begin
                        reg_req   <= (kind == FK_REG);
                        bus_req   <= (kind == FK_BUS);
                        acc_we    <= rx_rw;
                        acc_addr  <= rx_addr;
                        acc_wdata <= rx_data;
                    end
                end
            end
        end
    end

    // Latch read results in the request cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf        <= '0;
            rdata_valid <= 1'b0;
        end else if (reg_req && !acc_we) begin
            rbuf        <= reg_rdata;
            rdata_valid <= reg_ack;
        end else if (bus_req && !acc_we) begin
            rbuf        <= bus_rdata;
            rdata_valid <= 1'b1;
        end else if (reg_req || bus_req) begin
            rdata_valid <= 1'b0;
        end
    end

    jdbg_tx_shift #(.W(DW)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture_dr),
        .shift (shift_dr),
        .din   (ir_debug ? rbuf : '0),
        .tdo   (tdo)
    );

    assert_req_follows_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req || bus_req) |-> $past(update_dr));
    assert_req_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> !reg_req);
    assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_req, bus_req}));
    assert_err_blocks_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && $past(update_dr)) |-> (!reg_req && !bus_req));
    assert_chain_only_on_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_id != $past(chain_id)) |-> $past(update_dr && ir_chain_sel));
endmodule

// File: tb/jtag_dbg_frame_dec_test.sv
module jtag_dbg_frame_dec_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic        ir_chain_sel = 0, ir_debug = 0, tdi = 0;
    logic        tdo, crc_err, reg_req, bus_req, acc_we, rdata_valid, reg_ack;
    logic [3:0]  chain_id;
    logic [31:0] acc_addr, acc_wdata, reg_rdata, bus_rdata;

    int checks = 0, fails = 0;
    bit cmp_on = 0, finished = 0;

    // model state
    logic [3:0]  m_chain = 0;
    logic        m_err = 0, m_rvalid = 0, e_reg = 0, e_bus = 0, e_we = 0;
    logic [31:0] m_rbuf = 0, e_addr = 0, e_data = 0;

    always #10 clk = ~clk;

    // responders: registers 0..7 exist
    assign reg_ack   = acc_addr < 32'd8;
    assign reg_rdata = 32'h5A5A0000 | acc_addr;
    assign bus_rdata = ~acc_addr;

    jtag_dbg_frame_dec uut (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .ir_chain_sel(ir_chain_sel), .ir_debug(ir_debug),
        .tdi(tdi), .tdo(tdo), .chain_id(chain_id), .crc_err(crc_err),
        .reg_req(reg_req), .bus_req(bus_req), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
        .bus_rdata(bus_rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R2: CRC-8, poly x^8+x^2+x+1, preset all ones, serial in shift order
    function automatic logic [7:0] crc_ref(input logic [127:0] b, input int n);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < n; i++) c = {c[6:0], 1'b0} ^ ((c[7] ^ b[i]) ? 8'h07 : 8'h00);
        return c;
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) if (cmp_on) begin
        chk("R4 reg_req", {31'b0, reg_req}, {31'b0, e_reg});
        chk("R5 bus_req", {31'b0, bus_req}, {31'b0, e_bus});
        chk("R3 chain_id", {28'b0, chain_id}, {28'b0, m_chain});
        chk("R2 crc_err", {31'b0, crc_err}, {31'b0, m_err});
        chk("R8 rdata_valid", {31'b0, rdata_valid}, {31'b0, m_rvalid});
        if (e_reg || e_bus) begin
            chk("R4 acc_we", {31'b0, acc_we}, {31'b0, e_we});
            chk("R4 acc_addr", acc_addr, e_addr);
            chk("R4 acc_wdata", acc_wdata, e_data);
        end
    end

    // Drives capture, n shift cycles, exit, update; R1 LSB first; R7 tdo check.
    task automatic run_frame(input logic [127:0] b, input int n);
        int kind, alen, plen, bad;
        logic [31:0] img;
        logic ok;
        kind = ir_chain_sel ? 1 : !ir_debug ? 0 : (m_chain == 4'h1) ? 2 :
               (m_chain == 4'h2 || (m_chain >= 4'h8 && m_chain <= 4'hB)) ? 3 : 0;
        alen = (kind == 1) ? 4 : (kind == 2) ? 5 : 32;
        plen = (kind == 1) ? 4 : alen + 33;
        img  = ir_debug ? m_rbuf : 32'h0;
        bad  = 0;
        @(negedge clk) capture_dr = 1;
        @(negedge clk) capture_dr = 0; shift_dr = 1;
        for (int i = 0; i < n; i++) begin
            tdi = b[i];
            if (tdo !== ((i < 32) ? img[i] : 1'b0)) bad++;
            @(negedge clk);
        end
        shift_dr = 0; tdi = 0;
        chk("R7 tdo serial read data mismatches", bad, 0);
        @(negedge clk) update_dr = 1;
        @(posedge clk) #2;
        ok = (n >= plen + 8) && (crc_ref(b, plen) == b[plen +: 8]);
        if (kind != 0) begin
            m_err = !ok;
            if (ok && kind == 1) m_chain = b[3:0];
            if (ok && kind >= 2) begin
                e_reg = (kind == 2); e_bus = (kind == 3); e_we = b[alen];
                e_addr = 0;
                for (int i = 0; i < alen; i++) e_addr[i] = b[i];
                for (int i = 0; i < 32; i++) e_data[i] = b[alen + 1 + i];
            end
        end
        @(negedge clk) update_dr = 0;
        @(posedge clk) #2;
        if (e_reg || e_bus) begin
            if (e_we) m_rvalid = 0;
            else if (e_reg) begin m_rbuf = 32'h5A5A0000 | e_addr; m_rvalid = e_addr < 8; end
            else begin m_rbuf = ~e_addr; m_rvalid = 1; end
        end
        e_reg = 0; e_bus = 0;
        @(negedge clk);
    endtask

    task automatic do_select(input logic [3:0] id, input logic flip);
        logic [127:0] b = '0;
        logic [7:0] c;
        ir_chain_sel = 1; ir_debug = 0;
        b[3:0] = id;
        c = crc_ref(b, 4) ^ {7'b0, flip};
        b[11:4] = c;
        run_frame(b, 12);
        ir_chain_sel = 0;
    endtask

    // adj < 0 truncates the frame, adj > 0 appends extra bits
    task automatic do_acc(input logic [31:0] a, input logic we, input logic [31:0] d,
                          input logic flip, input int adj);
        logic [127:0] b = '0;
        logic [7:0] c;
        int alen, p;
        ir_debug = 1;
        alen = (m_chain == 4'h1) ? 5 : 32;
        for (int i = 0; i < alen; i++) b[i] = a[i];
        b[alen] = we;
        for (int i = 0; i < 32; i++) b[alen + 1 + i] = d[i];
        p = alen + 33;
        c = crc_ref(b, p) ^ {7'b0, flip};
        for (int i = 0; i < 8; i++) b[p + i] = c[i];
        if (adj > 0) b[p + 8] = 1'b1;
        run_frame(b, p + 8 + adj);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 chain_id", {28'b0, chain_id}, 0);
        chk("R10 crc_err", {31'b0, crc_err}, 0);
        chk("R10 reqs", {30'b0, reg_req, bus_req}, 0);
        chk("R10 rdata_valid", {31'b0, rdata_valid}, 0);
        chk("R10 tdo", {31'b0, tdo}, 0);
        rst_n = 1; cmp_on = 1;
        @(negedge clk);
        // R6: no chain yet, debug frame does nothing
        do_acc(32'h1, 1, 32'h1111, 0, 0);
        do_select(4'h1, 0);
        chk("R1 chain id received LSB first", {28'b0, chain_id}, 32'h1);
        do_acc(32'd3, 1, 32'hDEADBEEF, 0, 0);      // R4 write
        do_acc(32'd5, 0, 32'h0, 0, 0);             // R4 read
        chk("R8 valid after existing read", {31'b0, rdata_valid}, 1);
        do_acc(32'd20, 0, 32'h0, 0, 0);            // R7 shows addr5 data, R8 missing reg
        chk("R8 invalid for missing register", {31'b0, rdata_valid}, 0);
        do_acc(32'd2, 1, 32'h12, 1, 0);            // R2 bad CRC
        chk("R2 error flag after bad CRC", {31'b0, crc_err}, 1);
        do_acc(32'd2, 1, 32'h34, 0, 0);            // R2 clears
        do_acc(32'd4, 1, 32'h56, 0, -3);           // R9 truncated
        chk("R9 truncated frame flagged", {31'b0, crc_err}, 1);
        do_acc(32'd6, 0, 32'h0, 0, 1);             // R9 extra bit ignored
        chk("R9 extra bits ignored", {31'b0, crc_err}, 0);
        do_select(4'h2, 1);                        // R3 bad select
        chk("R3 chain kept after bad select", {28'b0, chain_id}, 32'h1);
        do_select(4'hA, 0);
        do_acc(32'h12345678, 1, 32'hCAFEF00D, 0, 0); // R5
        do_acc(32'h87654321, 0, 32'h0, 0, 0);
        do_acc(32'h0000FFFF, 0, 32'h0, 0, 0);      // R7 shows ~87654321
        do_select(4'h2, 0);
        do_acc(32'hA0000004, 1, 32'h0BADF00D, 0, 0);
        do_acc(32'hA0000008, 0, 32'h0, 1, 0);      // err set
        do_select(4'h3, 0);                        // trace chain
        do_acc(32'h1, 1, 32'h1, 1, 0);
        chk("R6 trace chain leaves crc_err", {31'b0, crc_err}, 0);
        ir_debug = 0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule